// File: doc/BRIEF.md
# Bitwise Parallel Minimum-Distance Winner Selector

This block picks the winning neuron of a self-organizing map. Each neuron supplies one unsigned distance, and all of them arrive on a single packed bus. The winner is the neuron whose distance is smallest.

The search runs over the bit positions of the distances, starting with the most significant bit. At each bit position every candidate that is still in the running is examined at the same time. If any of them has a 0 at that bit, every candidate with a 1 there is dropped. If none has a 0, all of them stay. The chain of eliminations is purely combinational and has one stage per distance bit, so its depth depends on the distance width and not on the neuron count.

When several neurons are left after the last bit, they share the minimum distance, and the one with the lowest index wins. A thin registered wrapper samples the result whenever the input strobe is high. It presents the result as a one-hot mask and as a binary index, together with a valid flag, one cycle after the strobe.

Top module: `winner_select`

## Requirements
- R1: `valid_o` is high in exactly the cycle after a clock edge at which `valid_i` was high. Latency is one clock whatever the value of `N`.
- R2: Once a result has been captured, `win_mask_o` has exactly one bit set.
- R3: The neuron selected by `win_mask_o` has a distance less than or equal to every other neuron's distance. Neuron k's distance is `dist_i[k*W +: W]`.
- R4: When several neurons share the minimum distance, the one with the lowest index is chosen.
- R5: `win_idx_o` is the binary position of the set bit in `win_mask_o`.
- R6: While `valid_i` is low, changes on `dist_i` have no effect, and `win_mask_o` and `win_idx_o` keep their last captured values.
- R7: While `rst_ni` is low, `valid_o`, `win_mask_o` and `win_idx_o` are all zero.
- R8: When all distances are equal, neuron 0 wins. This holds both when every bit is 1 and when every bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Capture strobe for `dist_i` |
| dist_i | input | N*W | Packed distances; neuron k occupies bits k*W+W-1..k*W |
| valid_o | output | 1 | Result valid, one cycle after `valid_i` |
| win_mask_o | output | N | One-hot winner mask |
| win_idx_o | output | max(1,ceil(log2 N)) | Binary winner index |

## Verification
The assertions check on every cycle the following:
- the one-cycle relation between the strobe and `valid_o`;
- that the mask has exactly one bit set;
- that the index agrees with the mask;
- that the outputs hold while the strobe is low.

Inside the logic, they also check that each elimination stage only removes candidates and never empties a non-empty set, and that the priority pick yields exactly one grant.

Only the bench scenarios can show that the chosen neuron really has the minimum distance. Those scenarios also cover lowest-index tie-breaking, equal-distance vectors and reset behaviour, because each needs a reference minimum computed from the stimulus.

// File: rtl/winsel_pkg.sv
package winsel_pkg;
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/winsel_step.sv
module winsel_step #(
  parameter int N = 64
) (
  input  logic [N-1:0] act_i,
  input  logic [N-1:0] col_i,
  output logic [N-1:0] act_o
);
  logic [N-1:0] zero_hit;

  assign zero_hit = act_i & ~col_i;
  // drop ones only if some active candidate shows a zero
  assign act_o = (|zero_hit) ? zero_hit : act_i;

  always_comb begin
    p_subset_r3: assert ((act_o & ~act_i) == '0);
    p_nonempty_r2: assert ((act_i == '0) || (act_o != '0));
  end
endmodule

// File: rtl/winsel_elim.sv
module winsel_elim #(
  parameter int N = 64,
  parameter int W = 6
) (
  input  logic [N*W-1:0] dist_i,
  output logic [N-1:0]   surv_o
);
  logic [N-1:0] col   [W];
  logic [N-1:0] chain [W+1];

  assign chain[W] = '1;

  for (genvar b = 0; b < W; b++) begin : g_bit
    for (genvar k = 0; k < N; k++) begin : g_col
      assign col[b][k] = dist_i[k*W+b];
    end
    winsel_step #(.N(N)) u_step (
      .act_i (chain[b+1]),
      .col_i (col[b]),
      .act_o (chain[b])
    );
  end

  assign surv_o = chain[0];
endmodule

// File: rtl/winsel_pick.sv
module winsel_pick #(
  parameter int N  = 64,
  parameter int IW = 6
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  sel_o,
  output logic [IW-1:0] idx_o
);
  logic found;

  always_comb begin
    sel_o = '0;
    idx_o = '0;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (req_i[k] && !found) begin
        sel_o[k] = 1'b1;
        idx_o    = IW'(k);
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    p_single_grant_r4: assert ((req_i == '0) || ($countones(sel_o) == 1));
    p_grant_in_req_r4: assert ((sel_o & ~req_i) == '0);
  end
endmodule

// File: rtl/winner_select.sv
module winner_select #(
  parameter int  N  = 64,
  parameter int  W  = 6,
  localparam int IW = winsel_pkg::idx_width(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [N*W-1:0] dist_i,
  output logic          valid_o,
  output logic [N-1:0]  win_mask_o,
  output logic [IW-1:0] win_idx_o
);
  logic [N-1:0]  surv;
  logic [N-1:0]  sel;
  logic [IW-1:0] idx;
  logic          armed_q;
  logic          captured_q;

  winsel_elim #(.N(N), .W(W)) u_elim (
    .dist_i (dist_i),
    .surv_o (surv)
  );

  winsel_pick #(.N(N), .IW(IW)) u_pick (
    .req_i (surv),
    .sel_o (sel),
    .idx_o (idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      win_mask_o <= '0;
      win_idx_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        win_mask_o <= sel;
        win_idx_o  <= idx;
      end
    end
  end

  // checker bookkeeping: cycles since reset and first capture
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q    <= 1'b0;
      captured_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      if (valid_i) captured_q <= 1'b1;
    end
  end

  p_valid_lag_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> (valid_o == $past(valid_i)));

  p_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    captured_q |-> ($countones(win_mask_o) == 1));

  p_idx_match_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    captured_q |-> win_mask_o[win_idx_o]);

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !valid_i) |=> ($stable(win_mask_o) && $stable(win_idx_o)));

  p_reset_r7: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && win_mask_o == '0 && win_idx_o == '0));
endmodule

// File: tb/sim_winner_select.sv
module sim_winner_select;
  localparam int NB = 8;
  localparam int WB = 4;
  localparam int IB = 3;
  localparam int NV = 9;

  localparam logic [NB*WB-1:0] VEC [NV] = '{
    32'h76543210, 32'h01234567, 32'hFFFFFFFF, 32'h00000000, 32'h9A3B5C3D,
    32'h8FFFFFFF, 32'hF7FFF7FF, 32'h1F2F3F4F, 32'hEEE6EEEE
  };
  localparam int EXP [NV] = '{0, 7, 0, 0, 1, 7, 2, 7, 4};

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [NB*WB-1:0] dist_i = '0;
  logic          valid_o;
  logic [NB-1:0] win_mask_o;
  logic [IB-1:0] win_idx_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  winner_select #(.N(NB), .W(WB)) u0 (
    .clk_i, .rst_ni, .valid_i, .dist_i, .valid_o, .win_mask_o, .win_idx_o
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ref_argmin(input logic [NB*WB-1:0] d);
    int best = 0;
    for (int k = 1; k < NB; k++)
      if (d[k*WB +: WB] < d[best*WB +: WB]) best = k;
    return best;
  endfunction

  task automatic check_result(input string req, input int exp);
    chk({req, " valid"}, valid_o, 1);
    chk({req, " idx"}, win_idx_o, exp);
    chk({req, " mask"}, win_mask_o, longint'(1) << exp);
  endtask

  task automatic apply(input logic [NB*WB-1:0] d);
    @(negedge clk_i);
    dist_i  = d;
    valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  initial begin
    // R7 reset state
    #5;
    chk("R7 valid", valid_o, 0);
    chk("R7 mask", win_mask_o, 0);
    chk("R7 idx", win_idx_o, 0);
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R3 R4 R5 R8 vector table
    for (int v = 0; v < NV; v++) begin
      apply(VEC[v]);
      check_result("R3", EXP[v]);
      chk("R4 ref", EXP[v], ref_argmin(VEC[v]));
      @(negedge clk_i);
      chk("R1 drop", valid_o, 0);
    end

    // R8 all-ones and all-zeros
    apply('1);
    check_result("R8 ones", 0);
    apply('0);
    check_result("R8 zeros", 0);

    // R6 dist changes without strobe are ignored
    apply(32'h0FFFFFFF);
    check_result("R6 base", 7);
    dist_i = 32'hFFFFFFF0;
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R6 idx", win_idx_o, 7);
    chk("R6 mask", win_mask_o, 8'h80);
    chk("R6 valid", valid_o, 0);

    // R1 back-to-back strobes
    @(negedge clk_i);
    dist_i  = 32'hFFFFF1FF;
    valid_i = 1'b1;
    @(negedge clk_i);
    check_result("R1 first", 2);
    dist_i = 32'h2FFFFFFF;
    @(negedge clk_i);
    valid_i = 1'b0;
    check_result("R1 second", 7);

    // R4 tie at index 3 and 6
    apply(32'hF5F95FFF);
    check_result("R4 tie", 3);

    // R7 mid-run reset
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R7 mid valid", valid_o, 0);
    chk("R7 mid mask", win_mask_o, 0);
    chk("R7 mid idx", win_idx_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    apply(32'h3FFFFFFF);
    check_result("R2 after reset", 7);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule